// File: doc/BRIEF.md
# Hex Record Text Stream Formatter

This block turns a span of byte-addressed memory into a printable hexadecimal record listing. A caller supplies a 16-bit start address and a byte count and pulses a start strobe. The block then reads the bytes one at a time through a synchronous read port and emits the listing as ASCII characters, one per accepted transfer, on a valid/ready byte interface. A UART or any other byte sink can consume that interface.

The span is cut into data records of bounded length. Each record carries a length field, the address of its first byte, a type field of zero, the data as hex digit pairs, and a closing checksum. After the data records comes a fixed terminating record. Line breaks separate the records, so the text can be captured straight into a file. The memory port has one cycle of read latency. A one-entry prefetch buffer lets the next byte arrive while the digits of the current byte are still being sent.

Top module: `hexrec_stream`

## Requirements
- R1: `start` is accepted only while `busy` is low, and `busy` is high in the cycle after an accepted start. A `start` pulse while `busy` is high changes neither the character stream nor the reads.
- R2: The span is split into data records of at most MAX_REC bytes (default 32), in ascending address order. Every record except the last holds exactly MAX_REC bytes, and the last holds the remainder. Each record's address field is the address of its first byte.
- R3: A data record is the character ':', then the length as 2 hex digits, the record address as 4 hex digits (most significant first), the two characters "00", and then each data byte as 2 hex digits (high nibble first). Digit values 0..9 are sent as 0x30..0x39 and 10..15 as uppercase 0x41..0x46.
- R4: The last field of a data record is 2 hex digits holding the two's complement of the low 8 bits of the sum of the length, the address high byte, the address low byte and every data byte of that record.
- R5: A line break, CR (0x0D) followed by LF (0x0A), comes before every record. After the last data record, the terminating record ":00000001FF" is sent, followed by one more CR LF.
- R6: A byte count of zero produces no data records and no reads. The stream is exactly CR LF ":00000001FF" CR LF.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_char` does not change. Every character is transferred exactly once, in order.
- R8: Reads are single-cycle `rd_en` pulses that are never back to back. The addresses run upward from the start address with each byte read exactly once, so one run makes exactly byte-count reads. `rd_data` is taken in the cycle after `rd_en`.
- R9: `done` is high for exactly one cycle, the cycle after the final LF is accepted. `busy` is low in that cycle, and `out_valid` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a listing (accepted only while idle) |
| start_addr | input | 16 | Address of the first byte |
| byte_count | input | CNT_W | Number of bytes to list |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| out_valid | output | 1 | A character is offered |
| out_char | output | 8 | ASCII character |
| out_ready | input | 1 | Sink accepts the character this cycle |
| busy | output | 1 | A listing is in progress |
| done | output | 1 | One-cycle pulse after the final LF is taken |

## Verification
The riskiest overlap is a prefetch read landing in the same cycle that the sink stalls the output register. The low digit of one byte is waiting for `out_ready` while the next byte returns from memory. A record boundary may also fall at that point. This is provoked by running multi-record spans, including the 32- and 33-byte edges, against pseudo-random ready patterns of both high and low acceptance. It is judged by comparing the captured text character for character with a listing built independently in the bench, and by checking the exact sequence and number of read addresses.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_ZERO  = 8'h30;
    localparam int         EOF_LAST = 10;

    typedef enum logic [4:0] {
        S_IDLE, S_CR, S_LF, S_COLON,
        S_LEN_H, S_LEN_L,
        S_ADR3, S_ADR2, S_ADR1, S_ADR0,
        S_TYP_H, S_TYP_L,
        S_DAT_H, S_DAT_L,
        S_SUM_H, S_SUM_L,
        S_EOF, S_FIN_CR, S_FIN_LF, S_DRAIN
    } frm_state_t;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  len;
        logic [7:0]  cnt;
        logic [7:0]  sum;
    } rec_ctx_t;

    function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
        if (nib < 4'd10) return 8'h30 + {4'h0, nib};
        else             return 8'h37 + {4'h0, nib};
    endfunction

    // Characters of the terminating record, indexed 0..EOF_LAST.
    function automatic logic [7:0] eof_char(input logic [3:0] idx);
        if (idx == 4'd0)      return CH_COLON;
        else if (idx <= 4'd7) return CH_ZERO;
        else if (idx == 4'd8) return 8'h31;
        else                  return 8'h46;
    endfunction

endpackage

// File: rtl/hexrec_fetch.sv
module hexrec_fetch #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [15:0]      go_addr,
    input  logic [CNT_W-1:0] go_count,
    input  logic             consume,
    output logic             rd_en,
    output logic [15:0]      rd_addr,
    input  logic [7:0]       rd_data,
    output logic             buf_valid,
    output logic [7:0]       buf_data
);
    logic [15:0]      faddr;
    logic [CNT_W-1:0] fleft;
    logic             inflight;

    assign rd_en   = (fleft != '0) && !inflight && (!buf_valid || consume);
    assign rd_addr = faddr;

    always_ff @(posedge clk) begin
        if (rst) begin
            faddr     <= '0;
            fleft     <= '0;
            inflight  <= 1'b0;
            buf_valid <= 1'b0;
            buf_data  <= '0;
        end else if (go) begin
            faddr     <= go_addr;
            fleft     <= go_count;
            inflight  <= 1'b0;
            buf_valid <= 1'b0;
        end else begin
            inflight <= rd_en;
            if (rd_en) begin
                faddr <= faddr + 16'd1;
                fleft <= fleft - 1'b1;
            end
            if (inflight) begin
                buf_valid <= 1'b1;
                buf_data  <= rd_data;
            end else if (consume) begin
                buf_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hexrec_emit.sv
module hexrec_emit (
    input  logic       clk,
    input  logic       rst,
    input  logic       ch_valid,
    input  logic [7:0] ch,
    output logic       can_load,
    output logic       accepted,
    output logic       out_valid,
    output logic [7:0] out_char,
    input  logic       out_ready
);
    assign can_load = !out_valid || out_ready;
    assign accepted = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_char  <= '0;
        end else if (ch_valid && can_load) begin
            out_valid <= 1'b1;
            out_char  <= ch;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/hexrec_framer.sv
module hexrec_framer
    import hexrec_pkg::*;
#(
    parameter int CNT_W   = 17,
    parameter int MAX_REC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [15:0]      go_addr,
    input  logic [CNT_W-1:0] go_count,
    input  logic             buf_valid,
    input  logic [7:0]       buf_data,
    input  logic             can_load,
    input  logic             accepted,
    output logic             ch_valid,
    output logic [7:0]       ch,
    output logic             consume,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_REC);
    localparam logic [7:0]       MAX_B = 8'(MAX_REC);

    frm_state_t       st;
    rec_ctx_t         rec;
    logic [15:0]      addr;
    logic [CNT_W-1:0] left;
    logic [7:0]       cur_byte;
    logic [3:0]       eidx;
    logic [7:0]       rec_n;
    logic [7:0]       chk;
    logic             take;

    always_comb begin
        rec_n = (left > MAX_C) ? MAX_B : left[7:0];
        chk   = 8'd0 - rec.sum;
    end

    always_comb begin
        ch_valid = 1'b1;
        ch       = 8'h00;
        unique case (st)
            S_CR, S_FIN_CR: ch = CH_CR;
            S_LF, S_FIN_LF: ch = CH_LF;
            S_COLON:        ch = CH_COLON;
            S_LEN_H:        ch = hex_ascii(rec.len[7:4]);
            S_LEN_L:        ch = hex_ascii(rec.len[3:0]);
            S_ADR3:         ch = hex_ascii(rec.addr[15:12]);
            S_ADR2:         ch = hex_ascii(rec.addr[11:8]);
            S_ADR1:         ch = hex_ascii(rec.addr[7:4]);
            S_ADR0:         ch = hex_ascii(rec.addr[3:0]);
            S_TYP_H, S_TYP_L: ch = CH_ZERO;
            S_DAT_H: begin
                ch_valid = buf_valid;
                ch       = hex_ascii(buf_data[7:4]);
            end
            S_DAT_L:        ch = hex_ascii(cur_byte[3:0]);
            S_SUM_H:        ch = hex_ascii(chk[7:4]);
            S_SUM_L:        ch = hex_ascii(chk[3:0]);
            S_EOF:          ch = eof_char(eidx);
            default:        ch_valid = 1'b0;
        endcase
    end

    assign take    = ch_valid && can_load;
    assign consume = take && (st == S_DAT_H);
    assign busy    = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            rec      <= '0;
            addr     <= '0;
            left     <= '0;
            cur_byte <= '0;
            eidx     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (go) begin
                        addr <= go_addr;
                        left <= go_count;
                        st   <= S_CR;
                    end
                end
                S_DRAIN: begin
                    if (accepted) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end
                end
                default: begin
                    if (take) begin
                        case (st)
                            S_CR: st <= S_LF;
                            S_LF: begin
                                if (left == '0) begin
                                    eidx <= '0;
                                    st   <= S_EOF;
                                end else begin
                                    rec.len  <= rec_n;
                                    rec.cnt  <= rec_n;
                                    rec.addr <= addr;
                                    rec.sum  <= rec_n + addr[15:8] + addr[7:0];
                                    st       <= S_COLON;
                                end
                            end
                            S_COLON: st <= S_LEN_H;
                            S_LEN_H: st <= S_LEN_L;
                            S_LEN_L: st <= S_ADR3;
                            S_ADR3:  st <= S_ADR2;
                            S_ADR2:  st <= S_ADR1;
                            S_ADR1:  st <= S_ADR0;
                            S_ADR0:  st <= S_TYP_H;
                            S_TYP_H: st <= S_TYP_L;
                            S_TYP_L: st <= S_DAT_H;
                            S_DAT_H: begin
                                cur_byte <= buf_data;
                                rec.sum  <= rec.sum + buf_data;
                                st       <= S_DAT_L;
                            end
                            S_DAT_L: begin
                                addr    <= addr + 16'd1;
                                left    <= left - 1'b1;
                                rec.cnt <= rec.cnt - 8'd1;
                                st      <= (rec.cnt == 8'd1) ? S_SUM_H : S_DAT_H;
                            end
                            S_SUM_H: st <= S_SUM_L;
                            S_SUM_L: st <= S_CR;
                            S_EOF: begin
                                if (eidx == 4'(EOF_LAST)) st <= S_FIN_CR;
                                else                      eidx <= eidx + 4'd1;
                            end
                            S_FIN_CR: st <= S_FIN_LF;
                            S_FIN_LF: st <= S_DRAIN;
                            default:  st <= S_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hexrec_stream.sv
module hexrec_stream #(
    parameter int CNT_W   = 17,
    parameter int MAX_REC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      start_addr,
    input  logic [CNT_W-1:0] byte_count,
    output logic             rd_en,
    output logic [15:0]      rd_addr,
    input  logic [7:0]       rd_data,
    output logic             out_valid,
    output logic [7:0]       out_char,
    input  logic             out_ready,
    output logic             busy,
    output logic             done
);
    logic       go;
    logic       buf_valid;
    logic [7:0] buf_data;
    logic       consume;
    logic       ch_valid;
    logic [7:0] ch;
    logic       can_load;
    logic       accepted;

    assign go = start && !busy;

    hexrec_fetch #(.CNT_W(CNT_W)) u_fetch (
        .clk(clk), .rst(rst), .go(go), .go_addr(start_addr), .go_count(byte_count),
        .consume(consume), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .buf_valid(buf_valid), .buf_data(buf_data)
    );

    hexrec_framer #(.CNT_W(CNT_W), .MAX_REC(MAX_REC)) u_framer (
        .clk(clk), .rst(rst), .go(go), .go_addr(start_addr), .go_count(byte_count),
        .buf_valid(buf_valid), .buf_data(buf_data), .can_load(can_load),
        .accepted(accepted), .ch_valid(ch_valid), .ch(ch), .consume(consume),
        .busy(busy), .done(done)
    );

    hexrec_emit u_emit (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch(ch), .can_load(can_load),
        .accepted(accepted), .out_valid(out_valid), .out_char(out_char),
        .out_ready(out_ready)
    );
endmodule

// File: rtl/hexrec_stream_chk.sv
module hexrec_stream_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        rd_en,
    input logic [15:0] rd_addr,
    input logic        out_valid,
    input logic [7:0]  out_char,
    input logic        out_ready,
    input logic        done
);
    logic        seen_rd;
    logic [15:0] last_rd;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) begin
            seen_rd <= 1'b0;
            last_rd <= '0;
        end else if (rd_en) begin
            seen_rd <= 1'b1;
            last_rd <= rd_addr;
        end
    end

    assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_char_legal_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_char >= 8'h30 && out_char <= 8'h39) ||
                       (out_char >= 8'h41 && out_char <= 8'h46) ||
                       out_char == 8'h3A || out_char == 8'h0D || out_char == 8'h0A));

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));

    assert_read_busy_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);

    assert_read_spaced_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    assert_read_ascending_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && seen_rd) |-> (rd_addr == last_rd + 16'd1));

    assert_done_after_lf_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(out_valid && out_ready && out_char == 8'h0A));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !out_valid));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind hexrec_stream hexrec_stream_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .rd_en(rd_en),
    .rd_addr(rd_addr), .out_valid(out_valid), .out_char(out_char),
    .out_ready(out_ready), .done(done)
);

// File: tb/hexrec_stream_tb.sv
module hexrec_stream_tb;
    localparam int CNT_W = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [15:0]      start_addr = '0;
    logic [CNT_W-1:0] byte_count = '0;
    logic             rd_en;
    logic [15:0]      rd_addr;
    logic [7:0]       rd_data = '0;
    logic             out_valid;
    logic [7:0]       out_char;
    logic             out_ready = 1'b1;
    logic             busy;
    logic             done;

    int checks = 0;
    int errors = 0;

    hexrec_stream #(.CNT_W(CNT_W), .MAX_REC(32)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_char(out_char), .out_ready(out_ready),
        .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= mem_val(rd_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Ready pattern, changed just after each rising edge.
    int         ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = lfsr[0];
            default: out_ready = (lfsr[1:0] == 2'b11);
        endcase
    end

    // Observation at the falling edge.
    logic [7:0]  got_q[$];
    logic [7:0]  exp_q[$];
    int          cyc = 0;
    int          last_cap = 0;
    int          done_count = 0;
    int          rd_count = 0;
    logic [15:0] exp_rd_addr = '0;
    logic        hold_pend = 1'b0;
    logic [7:0]  hold_ch = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            hold_pend = 1'b0;
        end else begin
            if (hold_pend)
                check(out_valid && out_char == hold_ch, "R7", "char held under stall",
                      int'(out_char), int'(hold_ch));
            if (out_valid && out_ready) begin
                got_q.push_back(out_char);
                last_cap = cyc;
            end
            hold_pend = out_valid && !out_ready;
            hold_ch   = out_char;
            if (rd_en) begin
                check(rd_addr == exp_rd_addr, "R8", "read address",
                      int'(rd_addr), int'(exp_rd_addr));
                exp_rd_addr = exp_rd_addr + 16'd1;
                rd_count++;
            end
            if (done) begin
                done_count++;
                check(cyc == last_cap + 1 && !busy, "R9", "done cycle after final LF",
                      cyc - last_cap, 1);
            end
        end
    end

    string HX = "0123456789ABCDEF";

    task automatic push_hex(input logic [7:0] b);
        exp_q.push_back(HX[b[7:4]]);
        exp_q.push_back(HX[b[3:0]]);
    endtask

    task automatic build_exp(input logic [15:0] a0, input int n);
        int          left = n;
        logic [15:0] a = a0;
        string       tail = ":00000001FF";
        exp_q.delete();
        while (left > 0) begin
            int         k = (left > 32) ? 32 : left;
            logic [7:0] s;
            exp_q.push_back(8'h0D);
            exp_q.push_back(8'h0A);
            exp_q.push_back(8'h3A);
            push_hex(8'(k));
            push_hex(a[15:8]);
            push_hex(a[7:0]);
            push_hex(8'h00);
            s = 8'(k) + a[15:8] + a[7:0];
            for (int i = 0; i < k; i++) begin
                logic [7:0] d = mem_val(a + 16'(i));
                push_hex(d);
                s = s + d;
            end
            push_hex(8'(-s));
            a = a + 16'(k);
            left = left - k;
        end
        exp_q.push_back(8'h0D);
        exp_q.push_back(8'h0A);
        for (int i = 0; i < tail.len(); i++) exp_q.push_back(tail[i]);
        exp_q.push_back(8'h0D);
        exp_q.push_back(8'h0A);
    endtask

    task automatic run_case(input string req, input logic [15:0] a, input int n,
                            input int mode, input bit poke);
        int bad = -1;
        build_exp(a, n);
        got_q.delete();
        rd_count    = 0;
        done_count  = 0;
        exp_rd_addr = a;
        ready_mode  = mode;
        @(posedge clk); #2;
        start_addr = a;
        byte_count = CNT_W'(n);
        start      = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        @(negedge clk);
        check(busy, "R1", "busy after accepted start", int'(busy), 1);
        if (poke) begin
            repeat (20) @(posedge clk);
            #2;
            start_addr = 16'h0100;
            byte_count = CNT_W'(5);
            start      = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
        end
        for (int w = 0; w < 60000 && done_count == 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(done_count == 1, "R9", "done pulse count", done_count, 1);
        check(got_q.size() == exp_q.size(), req, "stream length",
              got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
        if (bad < 0)
            check(1'b1, req, "stream text", 0, 0);
        else
            check(1'b0, req, $sformatf("stream char %0d", bad),
                  int'(got_q[bad]), int'(exp_q[bad]));
        check(rd_count == n, "R8", "read count", rd_count, n);
    endtask

    task automatic test_reset();
        check(!out_valid && !busy && !rd_en && !done, "R9", "idle after reset",
              {out_valid, busy, rd_en, done}, 0);
    endtask

    task automatic test_zero();      run_case("R6", 16'h4000, 0, 0, 1'b0); endtask
    task automatic test_single();    run_case("R3", 16'h1234, 1, 0, 1'b0); endtask
    task automatic test_full_rec();  run_case("R2", 16'h0000, 32, 0, 1'b0); endtask
    task automatic test_split();     run_case("R4", 16'h00F0, 33, 1, 1'b0); endtask
    task automatic test_long_slow(); run_case("R5", 16'hABC0, 70, 2, 1'b0); endtask
    task automatic test_restart();   run_case("R1", 16'h2222, 70, 1, 1'b1); endtask
    task automatic test_stall_ones();run_case("R7", 16'h7FFE, 3, 2, 1'b0); endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_zero();
        test_single();
        test_full_rec();
        test_split();
        test_long_slow();
        test_restart();
        test_stall_ones();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule